// File: doc/BRIEF.md
# Sectored Program Sequencer

This block keeps the program location and the sector selection state of a small accumulator machine. Each accepted instruction step presents a decoded 4-bit opcode, a 9-bit address field and the current accumulator value. The block then chooses the next program location. That location comes from one of four sources: sequential flow inside the current 256-word instruction sector, a short branch inside that sector, a conditional branch that tests the accumulator, or a long jump that reloads the whole sector state from a control word read from memory.

Short branches never leave the current instruction sector. The top address bit picks which syllable (half-word) of the target word runs. Leaving a sector needs a long jump, which always replaces every field of the control state. A separate sector-change instruction rewrites only the data-sector field.

For data operands and for the long-jump constant, the block resolves a memory location. The top address bit chooses between the current data sector and a fixed residual sector, and the low eight bits give the offset. The memory returns the control word on the same cycle.

Top module: `sector_seq`

## Requirements
- R1: After reset, the instruction sector, syllable, offset, data sector and taken flag are all zero.
- R2: While `step_i` is low, every state output keeps its value.
- R3: A step with any opcode other than 0000, 0100, 1000 or 1100 that is not a sector change (R9) advances the offset by one, wrapping from 255 to 0. It leaves the instruction sector, syllable and data sector unchanged.
- R4: Opcode 1000 always branches. The offset becomes address bits [7:0] and the syllable becomes address bit [8]. The instruction sector and data sector are unchanged.
- R5: Opcode 0100 branches as in R4 when the accumulator is not all zeros. Otherwise it advances as in R3.
- R6: Opcode 1100 branches as in R4 when the accumulator sign bit (MSB, two's complement) is set. Otherwise it advances as in R3.
- R7: Opcode 0000 loads all four fields from the 25-bit control word `jc_word_i`. The fields are instruction sector [24:17], syllable [16], offset [15:8] and data sector [7:0].
- R8: `opnd_offset_o` equals address bits [7:0]. `opnd_sector_o` equals the current data sector when address bit [8] is 0, and equals the residual sector (default 0xFF) when it is 1.
- R9: Opcode 1110 with address bit [8] at 0 sets the data sector to address bits [7:0] and advances the offset by one. The instruction sector and syllable are unchanged.
- R10: Opcode 1110 with address bit [8] at 1 leaves the data sector unchanged and advances as in R3.
- R11: `taken_o` is high for the cycle after a step that branched or jumped (R4 to R7), and low after any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Instruction step strobe |
| opcode_i | input | 4 | Decoded opcode |
| addr_i | input | 9 | Instruction address field |
| acc_i | input | ACC_W | Accumulator value |
| jc_word_i | input | 25 | Control word read from memory |
| opnd_sector_o | output | 8 | Resolved operand/constant sector |
| opnd_offset_o | output | 8 | Resolved operand/constant offset |
| isec_o | output | 8 | Current instruction sector |
| syl_o | output | 1 | Current syllable |
| off_o | output | 8 | Current instruction offset |
| dsec_o | output | 8 | Current data sector |
| taken_o | output | 1 | A branch or jump was taken on the last step |

## Verification
The assertions check on every cycle that idle cycles hold state and that short branches keep the instruction sector. They also check that the sign test agrees with the taken flag, that a zero accumulator never makes the nonzero test branch, and that a long jump copies its word whole. They further check that the residual sector is selected by the top address bit and that a sector change leaves the instruction sector and syllable alone. Only the bench scenarios show the offset wrap from 255 to 0, a long jump through the residual sector that lands on a new instruction sector, and long mixed instruction streams checked against a reference model.

// File: rtl/sector_seq_pkg.sv
package sector_seq_pkg;
    parameter int SEC_W  = 8;
    parameter int OFF_W  = 8;
    localparam int ADDR_W = OFF_W + 1;
    localparam int WORD_W = 2 * SEC_W + 1 + OFF_W;

    typedef enum logic [3:0] {
        OP_LJUMP = 4'b0000,
        OP_BNZ   = 4'b0100,
        OP_BRA   = 4'b1000,
        OP_BMI   = 4'b1100,
        OP_SECT  = 4'b1110
    } flow_op_e;

    typedef struct packed {
        logic [SEC_W-1:0] isec;
        logic             syl;
        logic [OFF_W-1:0] off;
        logic [SEC_W-1:0] dsec;
    } ctl_word_t;

    typedef struct packed {
        ctl_word_t ctl;
        logic      taken;
    } seq_state_t;
endpackage

// File: rtl/sq_cond_eval.sv
module sq_cond_eval
    import sector_seq_pkg::*;
#(
    parameter int ACC_W = 26
) (
    input  logic [3:0]       opcode,
    input  logic [ACC_W-1:0] acc,
    output logic             short_take,
    output logic             long_take
);
    logic acc_nz;
    logic acc_neg;

    always_comb begin
        acc_nz     = |acc;
        acc_neg    = acc[ACC_W-1];
        long_take  = (opcode == OP_LJUMP);
        unique case (opcode)
            OP_BRA:  short_take = 1'b1;
            OP_BNZ:  short_take = acc_nz;
            OP_BMI:  short_take = acc_neg;
            default: short_take = 1'b0;
        endcase
    end
endmodule

// File: rtl/sq_opnd_sel.sv
module sq_opnd_sel
    import sector_seq_pkg::*;
#(
    parameter logic [SEC_W-1:0] RES_SEC = '1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SEC_W-1:0]  dsec,
    output logic [SEC_W-1:0]  sector,
    output logic [OFF_W-1:0]  offset
);
    always_comb begin
        offset = addr[OFF_W-1:0];
        sector = addr[ADDR_W-1] ? RES_SEC : dsec;
    end
endmodule

// File: rtl/sq_word_unpack.sv
module sq_word_unpack
    import sector_seq_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output ctl_word_t         fields
);
    always_comb begin
        fields.isec = word[WORD_W-1 -: SEC_W];
        fields.syl  = word[OFF_W+SEC_W];
        fields.off  = word[SEC_W +: OFF_W];
        fields.dsec = word[SEC_W-1:0];
    end
endmodule

// File: rtl/sector_seq.sv
module sector_seq
    import sector_seq_pkg::*;
#(
    parameter int                ACC_W   = 26,
    parameter logic [SEC_W-1:0]  RES_SEC = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic [3:0]        opcode_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ACC_W-1:0]  acc_i,
    input  logic [WORD_W-1:0] jc_word_i,
    output logic [SEC_W-1:0]  opnd_sector_o,
    output logic [OFF_W-1:0]  opnd_offset_o,
    output logic [SEC_W-1:0]  isec_o,
    output logic              syl_o,
    output logic [OFF_W-1:0]  off_o,
    output logic [SEC_W-1:0]  dsec_o,
    output logic              taken_o
);
    seq_state_t state_d, state_q;
    logic       short_take;
    logic       long_take;
    logic       sect_chg;
    ctl_word_t  loaded;

    sq_cond_eval #(.ACC_W(ACC_W)) u_cond (
        .opcode     (opcode_i),
        .acc        (acc_i),
        .short_take (short_take),
        .long_take  (long_take)
    );

    sq_opnd_sel #(.RES_SEC(RES_SEC)) u_opnd (
        .addr   (addr_i),
        .dsec   (state_q.ctl.dsec),
        .sector (opnd_sector_o),
        .offset (opnd_offset_o)
    );

    sq_word_unpack u_unpack (
        .word   (jc_word_i),
        .fields (loaded)
    );

    always_comb begin
        sect_chg = (opcode_i == OP_SECT) && !addr_i[ADDR_W-1];
        state_d  = state_q;
        if (step_i) begin
            state_d.taken = 1'b0;
            if (long_take) begin
                state_d.ctl   = loaded;
                state_d.taken = 1'b1;
            end else if (short_take) begin
                state_d.ctl.off = addr_i[OFF_W-1:0];
                state_d.ctl.syl = addr_i[ADDR_W-1];
                state_d.taken   = 1'b1;
            end else begin
                state_d.ctl.off = state_q.ctl.off + 1'b1;
                if (sect_chg) begin
                    state_d.ctl.dsec = addr_i[SEC_W-1:0];
                end
            end
        end else begin
            state_d.taken = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        isec_o  = state_q.ctl.isec;
        syl_o   = state_q.ctl.syl;
        off_o   = state_q.ctl.off;
        dsec_o  = state_q.ctl.dsec;
        taken_o = state_q.taken;
    end
endmodule

// File: rtl/sector_seq_chk.sv
module sector_seq_chk
    import sector_seq_pkg::*;
#(
    parameter int               ACC_W   = 26,
    parameter logic [SEC_W-1:0] RES_SEC = '1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              step_i,
    input logic [3:0]        opcode_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [ACC_W-1:0]  acc_i,
    input logic [WORD_W-1:0] jc_word_i,
    input logic [SEC_W-1:0]  opnd_sector_o,
    input logic [SEC_W-1:0]  isec_o,
    input logic              syl_o,
    input logic [OFF_W-1:0]  off_o,
    input logic [SEC_W-1:0]  dsec_o,
    input logic              taken_o
);
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable({isec_o, syl_o, off_o, dsec_o}) && !taken_o); // R2
    AST_BRA_IN_SECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && opcode_i == 4'b1000) |=>
            isec_o == $past(isec_o) && off_o == $past(addr_i[OFF_W-1:0]) && syl_o == $past(addr_i[ADDR_W-1])); // R4
    AST_BNZ_ZERO_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && opcode_i == 4'b0100 && acc_i == '0) |=> !taken_o); // R5
    AST_BMI_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && opcode_i == 4'b1100) |=> taken_o == $past(acc_i[ACC_W-1])); // R6
    AST_LJUMP_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && opcode_i == 4'b0000) |=> {isec_o, syl_o, off_o, dsec_o} == $past(jc_word_i)); // R7
    AST_RESIDUAL_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        addr_i[ADDR_W-1] |-> opnd_sector_o == RES_SEC); // R8
    AST_SECT_KEEPS_ISEC: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && opcode_i == 4'b1110) |=> $stable({isec_o, syl_o}) && !taken_o); // R9
endmodule

bind sector_seq sector_seq_chk #(.ACC_W(ACC_W), .RES_SEC(RES_SEC)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .step_i        (step_i),
    .opcode_i      (opcode_i),
    .addr_i        (addr_i),
    .acc_i         (acc_i),
    .jc_word_i     (jc_word_i),
    .opnd_sector_o (opnd_sector_o),
    .isec_o        (isec_o),
    .syl_o         (syl_o),
    .off_o         (off_o),
    .dsec_o        (dsec_o),
    .taken_o       (taken_o)
);

// File: tb/sim_sector_seq.sv
`timescale 1ns/1ps
module sim_sector_seq;
    localparam int ACC_W = 26;
    localparam logic [7:0] RES = 8'hFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 1'b0;
    logic [3:0]  opcode_i = '0;
    logic [8:0]  addr_i = '0;
    logic [ACC_W-1:0] acc_i = '0;
    logic [24:0] jc_word_i = '0;
    logic [7:0]  opnd_sector_o, opnd_offset_o, isec_o, off_o, dsec_o;
    logic        syl_o, taken_o;

    int checks = 0;
    int errors = 0;
    logic [24:0] m_ctl;
    logic        m_tk;

    always #4 clk = ~clk;

    sector_seq #(.ACC_W(ACC_W), .RES_SEC(RES)) u0 (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .opcode_i(opcode_i),
        .addr_i(addr_i), .acc_i(acc_i), .jc_word_i(jc_word_i),
        .opnd_sector_o(opnd_sector_o), .opnd_offset_o(opnd_offset_o),
        .isec_o(isec_o), .syl_o(syl_o), .off_o(off_o), .dsec_o(dsec_o),
        .taken_o(taken_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [3:0] op, input logic a9);
        case (op)
            4'b0000: return "R7";
            4'b1000: return "R4";
            4'b0100: return "R5";
            4'b1100: return "R6";
            4'b1110: return a9 ? "R10" : "R9";
            default: return "R3";
        endcase
    endfunction

    // model update from requirements R3..R11
    task automatic model_step(input logic [3:0] op, input logic [8:0] a, input logic [ACC_W-1:0] acc,
                              input logic [24:0] w);
        logic br;
        br = (op == 4'b1000) || (op == 4'b0100 && acc != '0) || (op == 4'b1100 && acc[ACC_W-1]);
        m_tk = 1'b0;
        if (op == 4'b0000) begin
            m_ctl = w; m_tk = 1'b1;
        end else if (br) begin
            m_ctl[15:8] = a[7:0]; m_ctl[16] = a[8]; m_tk = 1'b1;
        end else begin
            m_ctl[15:8] = m_ctl[15:8] + 8'd1;
            if (op == 4'b1110 && !a[8]) m_ctl[7:0] = a[7:0];
        end
    endtask

    task automatic do_step(input logic [3:0] op, input logic [8:0] a, input logic [ACC_W-1:0] acc,
                           input logic [24:0] w);
        opcode_i = op; addr_i = a; acc_i = acc; jc_word_i = w; step_i = 1'b1;
        #1;
        check("R8", {opnd_sector_o, opnd_offset_o}, {(a[8] ? RES : m_ctl[7:0]), a[7:0]});
        model_step(op, a, acc, w);
        @(negedge clk);
        step_i = 1'b0;
        check(req_of(op, a[8]), {isec_o, syl_o, off_o, dsec_o}, m_ctl);
        check("R11", taken_o, m_tk);
    endtask

    initial begin
        #1_000_000;
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        m_ctl = '0; m_tk = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {isec_o, syl_o, off_o, dsec_o, taken_o}, 26'd0);

        // R2: idle cycles hold
        do_step(4'b0000, 9'h005, '0, {8'h3C, 1'b0, 8'hFE, 8'h21});
        repeat (3) @(negedge clk);
        check("R2", {isec_o, syl_o, off_o, dsec_o}, m_ctl);
        check("R2", taken_o, 1'b0);
        // R3 wrap 255 -> 0
        do_step(4'b0111, 9'h010, '0, '0);
        do_step(4'b0111, 9'h010, '0, '0);
        check("R3", off_o, 8'h00);
        // R5 zero acc falls through, nonzero branches
        do_step(4'b0100, 9'h1AA, '0, '0);
        do_step(4'b0100, 9'h1AA, 26'd1, '0);
        // R6 sign tests
        do_step(4'b1100, 9'h033, 26'h1FFFFFF, '0);
        do_step(4'b1100, 9'h044, 26'h2000000, '0);
        // R4 unconditional
        do_step(4'b1000, 9'h0FF, '0, '0);
        // R9 / R10 sector change
        do_step(4'b1110, 9'h07A, '0, '0);
        check("R9", dsec_o, 8'h7A);
        do_step(4'b1110, 9'h155, '0, '0);
        check("R10", dsec_o, 8'h7A);
        // R7 jump via residual sector
        do_step(4'b0000, 9'h100, '0, {8'h91, 1'b1, 8'h12, 8'h34});
        check("R7", isec_o, 8'h91);

        for (int i = 0; i < 3000; i++) begin
            logic [3:0] op;
            logic [ACC_W-1:0] acc;
            op = 4'($urandom);
            case ($urandom % 4)
                0: acc = '0;
                1: acc = {1'b1, 25'($urandom)};
                default: acc = ACC_W'($urandom);
            endcase
            if (($urandom % 5) == 0) @(negedge clk);
            do_step(op, 9'($urandom), acc, 25'($urandom));
        end

        // reset mid-run returns to zero
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", {isec_o, syl_o, off_o, dsec_o, taken_o}, 26'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule